// File: doc/BRIEF.md
# Dual-Priority Receive Buffer FIFO

The block sits between a frame receiver and host memory. The host posts empty receive buffers by address, each tagged as high or low priority, and the block keeps them in two independent address queues. When a frame arrives with its class tag, the block takes the oldest buffer from the queue of that class. It writes a fixed 12-byte completion record into the first three words of that buffer and the payload words straight after it, then announces the finished buffer on a completion output. The consumer skips the 12 header bytes to reach the data. Beacon, power-save poll and unscheduled-delivery frames are expected to arrive tagged high, and all other frames low. Classifying frames is done upstream and is not part of this block.

Memory is reached through a one-word write port with no back-pressure. A frame is offered as a header handshake (class, byte length, timestamp, error flags) followed by payload words that end with a last flag. Start and stop gate the acceptance of new frames. Flush returns every posted but unused address on a reclaim output.

The controller has eight states. IDLE waits for work. HDR0, HDR1 and HDR2 write the three header words. PAY writes payload words. DONE raises the completion. DROP swallows the payload of a frame whose class queue is empty. FLUSH drains both queues. The transitions are as follows. IDLE goes to FLUSH when a flush is pending, and this has priority. IDLE goes to HDR0 when a frame is accepted and its class queue holds a buffer. IDLE goes to DROP when a frame is accepted and its class queue is empty. HDR0 goes to HDR1, HDR1 to HDR2 and HDR2 to PAY, one step per cycle. PAY goes to DONE on the last payload word. DONE goes back to IDLE. DROP goes back to IDLE on the last payload word. FLUSH goes back to IDLE when both queues are empty.

Top module: `rx_dualprio_buf`

## Requirements
- R1: `post_class`=1 selects the high queue and 0 the low queue. A frame with `fr_class`=c uses the oldest buffer posted with class c, and each class is taken in posting order.
- R2: The word at the buffer address is {len[15:0], 7'b0, class, err[7:0]}, with len in bits 31:16, class in bit 8 and err in bits 7:0. The word at +4 is the 32-bit timestamp. The word at +8 is zero.
- R3: Payload word i (counting from 0) is written at buffer address + 12 + 4*i.
- R4: After the last payload write, `cmp_valid` is high for exactly one cycle, with `cmp_addr` equal to the buffer address and `cmp_class` equal to the frame class.
- R5: A frame whose class queue is empty is still accepted, but its payload is consumed with no memory write. The overrun counter of that class (`ovr_cnt_hi` or `ovr_cnt_lo`) increments by one.
- R6: `fr_ready` is low in the cycle after `ctl_stop`. A frame already in progress completes. `ctl_start` allows frames to be accepted again.
- R7: `ctl_flush` returns every queued address on `rcl_valid`/`rcl_addr`, one per cycle, all high-queue entries first and then the low-queue entries, each queue in posting order. Afterwards both queues are empty.
- R8: Each queue holds 16 addresses. A post to a full queue raises `post_err` for one cycle, in the cycle after the post, and leaves the queue contents unchanged.
- R9: After reset the block is stopped (`fr_ready` low), both queues are empty, both counters are zero, and `wr_en`, `cmp_valid`, `rcl_valid` and `post_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Allow frame acceptance |
| ctl_stop | input | 1 | Stop accepting new frames (wins over start) |
| ctl_flush | input | 1 | Request a drain of both queues |
| post_valid | input | 1 | Post an empty buffer |
| post_class | input | 1 | 1 = high queue, 0 = low queue |
| post_addr | input | AW | Buffer address |
| post_err | output | 1 | Post to a full queue |
| fr_valid | input | 1 | Frame header offered |
| fr_ready | output | 1 | Frame header accepted |
| fr_class | input | 1 | Frame class tag |
| fr_len | input | 16 | Frame length in bytes |
| fr_tstamp | input | 32 | Receive timestamp |
| fr_errs | input | 8 | Error flags |
| pl_valid | input | 1 | Payload word valid |
| pl_ready | output | 1 | Payload word taken |
| pl_data | input | 32 | Payload word |
| pl_last | input | 1 | Last payload word |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory byte address |
| wr_data | output | 32 | Memory write data |
| cmp_valid | output | 1 | Buffer completed |
| cmp_addr | output | AW | Completed buffer address |
| cmp_class | output | 1 | Completed buffer class |
| rcl_valid | output | 1 | Reclaimed address valid |
| rcl_addr | output | AW | Reclaimed address |
| ovr_cnt_hi | output | CW | High-class drop count |
| ovr_cnt_lo | output | CW | Low-class drop count |

## Verification
The assertions check the following on every cycle. Queue occupancy never exceeds its depth. A post to a full queue pulses the error and leaves occupancy unchanged. A completion always directly follows a memory write. Stop removes `fr_ready` on the next cycle. An overrun counter only ever steps by one. Writes, completions and reclaims never coincide. The bench scenarios are needed for the rest: the contents written into memory, the order in which buffers are consumed per class, the reclaim order after a flush, and the choice between dropping and writing across random mixes of posts and frames.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int WORD_W    = 32;
    localparam int HDR_BYTES = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR0,
        S_HDR1,
        S_HDR2,
        S_PAY,
        S_DONE,
        S_DROP,
        S_FLUSH
    } rxb_state_t;
endpackage

// File: rtl/rxb_addr_fifo.sv
module rxb_addr_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf_err
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] store [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = store[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            ovf_err <= 1'b0;
        end else begin
            ovf_err <= push && full && !do_pop;
            if (do_push) begin
                wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            end
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= din;
    end

    // R8: occupancy bounded by depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (PW+1)'(DEPTH));
    // R8: a rejected post keeps occupancy and flags an error
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ($stable(cnt) && ovf_err));
endmodule

// File: rtl/rx_dualprio_buf.sv
module rx_dualprio_buf
    import rxb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    parameter int LENW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_flush,
    input  logic              post_valid,
    input  logic              post_class,
    input  logic [AW-1:0]     post_addr,
    output logic              post_err,
    input  logic              fr_valid,
    output logic              fr_ready,
    input  logic              fr_class,
    input  logic [LENW-1:0]   fr_len,
    input  logic [31:0]       fr_tstamp,
    input  logic [7:0]        fr_errs,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [WORD_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              cmp_valid,
    output logic [AW-1:0]     cmp_addr,
    output logic              cmp_class,
    output logic              rcl_valid,
    output logic [AW-1:0]     rcl_addr,
    output logic [CW-1:0]     ovr_cnt_hi,
    output logic [CW-1:0]     ovr_cnt_lo
);
    localparam int NQ = 2;

    rxb_state_t state, nstate;

    logic [NQ-1:0] q_push, q_pop, q_empty, q_full, q_ovf;
    logic [AW-1:0] q_head [NQ];

    logic            run_q, flush_pend;
    logic [AW-1:0]   buf_q;
    logic            cls_q;
    logic [LENW-1:0] len_q;
    logic [31:0]     ts_q;
    logic [7:0]      err_q;
    logic [LENW-1:0] idx_q;
    logic [CW-1:0]   ovr_q [NQ];

    logic accept, fl_sel;

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_q
            assign q_push[g] = post_valid && (post_class == g[0]);
            rxb_addr_fifo #(.DEPTH(DEPTH), .W(AW)) u_fifo (
                .clk    (clk),
                .rst_n  (rst_n),
                .push   (q_push[g]),
                .din    (post_addr),
                .pop    (q_pop[g]),
                .dout   (q_head[g]),
                .empty  (q_empty[g]),
                .full   (q_full[g]),
                .ovf_err(q_ovf[g])
            );
        end
    endgenerate

    assign post_err   = |q_ovf;
    assign ovr_cnt_hi = ovr_q[1];
    assign ovr_cnt_lo = ovr_q[0];
    assign accept     = (state == S_IDLE) && run_q && !flush_pend && fr_valid;
    assign fl_sel     = !q_empty[1];

    // next state and queue pops
    always_comb begin
        nstate = state;
        q_pop  = '0;
        unique case (state)
            S_IDLE: begin
                if (flush_pend) begin
                    nstate = S_FLUSH;
                end else if (accept) begin
                    if (q_empty[fr_class]) begin
                        nstate = S_DROP;
                    end else begin
                        nstate = S_HDR0;
                        q_pop[fr_class] = 1'b1;
                    end
                end
            end
            S_HDR0: nstate = S_HDR1;
            S_HDR1: nstate = S_HDR2;
            S_HDR2: nstate = S_PAY;
            S_PAY:  if (pl_valid && pl_last) nstate = S_DONE;
            S_DONE: nstate = S_IDLE;
            S_DROP: if (pl_valid && pl_last) nstate = S_IDLE;
            S_FLUSH: begin
                if (q_empty == '1) nstate = S_IDLE;
                else               q_pop[fl_sel] = 1'b1;
            end
            default: nstate = S_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            run_q      <= 1'b0;
            flush_pend <= 1'b0;
            buf_q      <= '0;
            cls_q      <= 1'b0;
            len_q      <= '0;
            ts_q       <= '0;
            err_q      <= '0;
            idx_q      <= '0;
            ovr_q[0]   <= '0;
            ovr_q[1]   <= '0;
        end else begin
            state <= nstate;
            if (ctl_stop)       run_q <= 1'b0;
            else if (ctl_start) run_q <= 1'b1;
            if (ctl_flush)                           flush_pend <= 1'b1;
            else if (state == S_IDLE && flush_pend)  flush_pend <= 1'b0;
            if (accept) begin
                buf_q <= q_head[fr_class];
                cls_q <= fr_class;
                len_q <= fr_len;
                ts_q  <= fr_tstamp;
                err_q <= fr_errs;
                if (q_empty[fr_class]) ovr_q[fr_class] <= ovr_q[fr_class] + 1'b1;
            end
            if (state == S_HDR2)           idx_q <= '0;
            else if (state == S_PAY && pl_valid) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        fr_ready  = (state == S_IDLE) && run_q && !flush_pend;
        pl_ready  = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = buf_q;
        wr_data   = '0;
        cmp_valid = 1'b0;
        cmp_addr  = buf_q;
        cmp_class = cls_q;
        rcl_valid = 1'b0;
        rcl_addr  = q_head[fl_sel];
        unique case (state)
            S_HDR0: begin
                wr_en   = 1'b1;
                wr_data = {len_q, 7'b0, cls_q, err_q};
            end
            S_HDR1: begin
                wr_en   = 1'b1;
                wr_addr = buf_q + AW'(4);
                wr_data = ts_q;
            end
            S_HDR2: begin
                wr_en   = 1'b1;
                wr_addr = buf_q + AW'(8);
            end
            S_PAY: begin
                pl_ready = 1'b1;
                wr_en    = pl_valid;
                wr_addr  = buf_q + AW'(HDR_BYTES) + AW'({idx_q, 2'b00});
                wr_data  = pl_data;
            end
            S_DONE:  cmp_valid = 1'b1;
            S_DROP:  pl_ready  = 1'b1;
            S_FLUSH: rcl_valid = (q_empty != '1);
            default: ;
        endcase
    end

    // R4: completion comes straight after the final write
    assert_cmp_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> $past(wr_en));
    // R6: stop removes frame acceptance on the next cycle
    assert_stop_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stop |=> !fr_ready);
    // R5: overrun counters step by at most one
    assert_ovr_step_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_cnt_hi != $past(ovr_cnt_hi)) |-> (ovr_cnt_hi == $past(ovr_cnt_hi) + 1'b1));
    assert_ovr_step_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_cnt_lo != $past(ovr_cnt_lo)) |-> (ovr_cnt_lo == $past(ovr_cnt_lo) + 1'b1));
    // R7: reclaim never overlaps writes or completions
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, cmp_valid, rcl_valid}));
endmodule

// File: tb/rx_dualprio_buf_tb_top.sv
module rx_dualprio_buf_tb_top;
    localparam int AW = 32;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_start = 0, ctl_stop = 0, ctl_flush = 0;
    logic post_valid = 0, post_class = 0;
    logic [AW-1:0] post_addr = '0;
    logic post_err;
    logic fr_valid = 0, fr_ready, fr_class = 0;
    logic [15:0] fr_len = '0;
    logic [31:0] fr_tstamp = '0;
    logic [7:0] fr_errs = '0;
    logic pl_valid = 0, pl_ready, pl_last = 0;
    logic [31:0] pl_data = '0;
    logic wr_en, cmp_valid, cmp_class, rcl_valid;
    logic [AW-1:0] wr_addr, cmp_addr, rcl_addr;
    logic [31:0] wr_data;
    logic [CW-1:0] ovr_cnt_hi, ovr_cnt_lo;

    always #5 clk = ~clk;

    rx_dualprio_buf #(.AW(AW), .DEPTH(16), .CW(CW), .LENW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_flush(ctl_flush), .post_valid(post_valid), .post_class(post_class),
        .post_addr(post_addr), .post_err(post_err), .fr_valid(fr_valid),
        .fr_ready(fr_ready), .fr_class(fr_class), .fr_len(fr_len),
        .fr_tstamp(fr_tstamp), .fr_errs(fr_errs), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_class(cmp_class),
        .rcl_valid(rcl_valid), .rcl_addr(rcl_addr),
        .ovr_cnt_hi(ovr_cnt_hi), .ovr_cnt_lo(ovr_cnt_lo)
    );

    int nchk = 0, nerr = 0;
    logic [31:0] mem [int unsigned];
    logic [AW-1:0] cmpq [$];
    logic cmpcls [$];
    logic [AW-1:0] rclq [$];
    logic [AW-1:0] mq_hi [$];
    logic [AW-1:0] mq_lo [$];
    int wr_cnt = 0, perr_seen = 0, perr_exp = 0;
    int ovr_exp_hi = 0, ovr_exp_lo = 0;
    logic [AW-1:0] next_addr = 32'h0000_1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                mem[wr_addr] = wr_data;
                wr_cnt++;
            end
            if (cmp_valid) begin
                cmpq.push_back(cmp_addr);
                cmpcls.push_back(cmp_class);
            end
            if (rcl_valid) rclq.push_back(rcl_addr);
            if (post_err) perr_seen++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr0(input logic [15:0] len, input logic cls, input logic [7:0] e);
        return {len, 7'b0, cls, e};
    endfunction

    function automatic logic [31:0] pay_word(input logic [31:0] ts, input int i);
        return ts ^ (32'(i) * 32'h9E37_79B9) ^ 32'h0000_5A5A;
    endfunction

    task automatic post(input logic cls);
        @(posedge clk); #1;
        post_valid = 1; post_class = cls; post_addr = next_addr;
        if (cls) begin
            if (mq_hi.size() < 16) mq_hi.push_back(next_addr); else perr_exp++;
        end else begin
            if (mq_lo.size() < 16) mq_lo.push_back(next_addr); else perr_exp++;
        end
        next_addr = next_addr + 32'h100;
        @(posedge clk); #1;
        post_valid = 0;
    endtask

    task automatic send_frame(input logic cls, input int nw, input logic [31:0] ts, input logic [7:0] e);
        @(posedge clk); #1;
        fr_valid = 1; fr_class = cls; fr_len = 16'(nw * 4); fr_tstamp = ts; fr_errs = e;
        forever begin
            @(negedge clk);
            if (fr_ready) break;
        end
        @(posedge clk); #1;
        fr_valid = 0;
        for (int i = 0; i < nw; i++) begin
            pl_valid = 1; pl_data = pay_word(ts, i); pl_last = (i == nw - 1);
            forever begin
                @(negedge clk);
                if (pl_ready) break;
            end
            @(posedge clk); #1;
        end
        pl_valid = 0; pl_last = 0;
    endtask

    task automatic do_frame(input logic cls, input int nw, input logic [31:0] ts, input logic [7:0] e);
        logic drop;
        logic [AW-1:0] a;
        int w0;
        drop = cls ? (mq_hi.size() == 0) : (mq_lo.size() == 0);
        a = '0;
        if (!drop) a = cls ? mq_hi.pop_front() : mq_lo.pop_front();
        w0 = wr_cnt;
        cmpq.delete(); cmpcls.delete();
        send_frame(cls, nw, ts, e);
        repeat (3) @(negedge clk);
        if (drop) begin
            if (cls) ovr_exp_hi++; else ovr_exp_lo++;
            chk(cmpq.size() == 0, "R5 no completion on drop", cmpq.size(), 0);
            chk(wr_cnt == w0, "R5 no writes on drop", wr_cnt - w0, 0);
            chk(ovr_cnt_hi == CW'(ovr_exp_hi), "R5 ovr_cnt_hi", ovr_cnt_hi, ovr_exp_hi);
            chk(ovr_cnt_lo == CW'(ovr_exp_lo), "R5 ovr_cnt_lo", ovr_cnt_lo, ovr_exp_lo);
        end else begin
            chk(cmpq.size() == 1, "R4 one completion", cmpq.size(), 1);
            if (cmpq.size() == 1) begin
                chk(cmpq[0] == a, "R1/R4 completion address", cmpq[0], a);
                chk(cmpcls[0] == cls, "R4 completion class", cmpcls[0], cls);
            end
            chk(mem.exists(a) && mem[a] == hdr0(16'(nw * 4), cls, e), "R2 header word0",
                mem.exists(a) ? mem[a] : 32'hx, hdr0(16'(nw * 4), cls, e));
            chk(mem.exists(a + 4) && mem[a + 4] == ts, "R2 timestamp word",
                mem.exists(a + 4) ? mem[a + 4] : 32'hx, ts);
            chk(mem.exists(a + 8) && mem[a + 8] == 32'h0, "R2 reserved word",
                mem.exists(a + 8) ? mem[a + 8] : 32'hx, 0);
            for (int i = 0; i < nw; i++) begin
                logic [AW-1:0] pa;
                pa = a + 12 + 4 * i;
                chk(mem.exists(pa) && mem[pa] == pay_word(ts, i), "R3 payload word",
                    mem.exists(pa) ? mem[pa] : 32'hx, pay_word(ts, i));
            end
            chk(wr_cnt - w0 == 3 + nw, "R3 write count", wr_cnt - w0, 3 + nw);
        end
    endtask

    task automatic do_flush();
        logic [AW-1:0] exp [$];
        foreach (mq_hi[i]) exp.push_back(mq_hi[i]);
        foreach (mq_lo[i]) exp.push_back(mq_lo[i]);
        rclq.delete();
        @(posedge clk); #1; ctl_flush = 1;
        @(posedge clk); #1; ctl_flush = 0;
        repeat (40) @(negedge clk);
        chk(rclq.size() == exp.size(), "R7 reclaim count", rclq.size(), exp.size());
        for (int i = 0; i < exp.size() && i < rclq.size(); i++)
            chk(rclq[i] == exp[i], "R7 reclaim order", rclq[i], exp[i]);
        mq_hi.delete(); mq_lo.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(fr_ready == 0, "R9 fr_ready after reset", fr_ready, 0);
        chk(wr_en == 0 && cmp_valid == 0 && rcl_valid == 0 && post_err == 0,
            "R9 outputs idle", {wr_en, cmp_valid, rcl_valid, post_err}, 0);
        chk(ovr_cnt_hi == 0 && ovr_cnt_lo == 0, "R9 counters zero", {ovr_cnt_hi, ovr_cnt_lo}, 0);

        @(posedge clk); #1 ctl_start = 1;
        @(posedge clk); #1 ctl_start = 0;

        // R9 queues empty after reset: frames of both classes drop
        do_frame(1'b1, 2, 32'hAAAA_0001, 8'h00);
        do_frame(1'b0, 1, 32'hAAAA_0002, 8'h00);

        // R1 class steering and order
        post(1'b1); post(1'b1); post(1'b0);
        do_frame(1'b0, 3, 32'h1234_5678, 8'h81);
        do_frame(1'b1, 1, 32'hCAFE_0001, 8'h00);
        do_frame(1'b1, 5, 32'hCAFE_0002, 8'h3C);
        do_frame(1'b1, 2, 32'hCAFE_0003, 8'h00);   // R5 high now empty

        // R6 stop/start
        post(1'b0);
        @(posedge clk); #1 ctl_stop = 1;
        @(posedge clk); #1 ctl_stop = 0; fr_valid = 1; fr_class = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(fr_ready == 0, "R6 no accept while stopped", fr_ready, 0);
        end
        @(posedge clk); #1 fr_valid = 0;
        chk(cmpq.size() == 0 && mq_lo.size() == 1, "R6 nothing consumed", cmpq.size(), 0);
        @(posedge clk); #1 ctl_start = 1;
        @(posedge clk); #1 ctl_start = 0;
        do_frame(1'b0, 2, 32'h0BAD_F00D, 8'h01);

        // R8 full queue and R7 flush
        for (int i = 0; i < 17; i++) post(1'b1);
        post(1'b0); post(1'b0);
        repeat (2) @(negedge clk);
        chk(perr_seen == perr_exp && perr_exp == 1, "R8 post_err on full", perr_seen, 1);
        do_flush();
        do_frame(1'b1, 1, 32'h0000_0F0F, 8'h00);   // R7 empty after flush
        do_frame(1'b0, 1, 32'h0000_0F1F, 8'h00);

        // random mix
        void'($urandom(32'd2024));
        for (int it = 0; it < 80; it++) begin
            int r;
            r = $urandom % 3;
            if (r == 0) do_frame(1'($urandom % 2), 1 + ($urandom % 6), $urandom, 8'($urandom));
            else post(1'($urandom % 2));
        end
        repeat (2) @(negedge clk);
        chk(perr_seen == perr_exp, "R8 post_err count random", perr_seen, perr_exp);
        do_flush();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #2_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule